// File: doc/BRIEF.md
# Byte-Stream Bootstrap Loader

This block brings a freshly reset machine to life by pulling a fixed-length program out of a byte-wide input stream, such as a paper-tape reader or a serial receiver. It writes the program into memory, then signals that control may pass to it. After a `start` pulse the machine discards input until it sees the sync value 2. It then packs each pair of bytes into a 16-bit word, high byte first. Each word is stored through a pointer that is advanced before every write, so the first word lands one above the base value. A word counter is preset to minus the word count and stepped once per store; loading ends when it wraps to zero. A single-cycle `done` pulse then presents the start address.

The `TAPE_MODE` parameter selects one of two variants.
- **Tape variant:** base octal 03677, start address octal 03700. After every data byte it takes, the loader waits for the reader-moving indication before it listens for the next byte.
- **Serial variant:** base octal 037677, start address octal 037700. It uses no handshake and accepts data bytes on consecutive cycles.

**States:**
- `ST_IDLE`: waits for `start`.
- `ST_HUNT`: discards bytes until the sync value arrives.
- `ST_HI_WAIT`: waits for the high byte.
- `ST_HI_GAP`: tape only; waits for reader motion after the high byte.
- `ST_LO_WAIT`: waits for the low byte and stores the word.
- `ST_LO_GAP`: tape only; waits for reader motion after the low byte.
- `ST_FINISH`: one cycle that leads to the done pulse.

**Transitions:**
- IDLE→HUNT on `start`.
- HUNT→HI_WAIT on a strobed byte equal to 2.
- HI_WAIT→HI_GAP (tape) or →LO_WAIT (serial) on a byte.
- HI_GAP→LO_WAIT on `rdr_moving`.
- LO_WAIT→LO_GAP (tape) on a byte.
- LO_WAIT→HI_WAIT or →FINISH (serial, last word) on a byte.
- LO_GAP→HI_WAIT or →FINISH (count expired) on `rdr_moving`.
- FINISH→IDLE unconditionally.

Top module: `boot_stream_loader`

## Requirements
- R1: After reset `mem_we` and `done` are low, and byte strobes arriving before any `start` pulse cause no memory write.
- R2: After `start`, strobed bytes whose value is not 2 are discarded and cause no write; the first strobed byte equal to 2 is the sync marker and is not stored.
- R3: Each stored word has the first data byte of the pair in bits 15..8 and the second in bits 7..0; a data byte equal to 2 after sync is ordinary data.
- R4: The first word of a load is written to base+1 (octal 03700 tape, 037700 serial) and every later word to the previous address plus one.
- R5: Exactly `WORD_COUNT` words (default 62, octal 076) are written per load, after which the loader stops storing.
- R6: `done` is high for exactly one cycle, one cycle after the loader reaches `ST_FINISH`, with `done_addr` equal to base+1 (octal 03700 tape, 037700 serial).
- R7: In the tape variant, after taking each data byte the loader takes no further byte until `rdr_moving` has been seen high; byte strobes in that gap are ignored, and `done` is not raised before the motion that follows the final byte.
- R8: In the serial variant data bytes strobed on consecutive cycles are all accepted, and `rdr_moving` is not needed.
- R9: After `done`, byte strobes are ignored until the next `start`, and a new `start` restarts the load at base+1.
- R10: `mem_we` is high for one cycle per stored word and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (honoured in `ST_IDLE` only) |
| byte_vld | input | 1 | Byte strobe, one per byte |
| byte_val | input | BYTE_W | Byte value qualified by `byte_vld` |
| rdr_moving | input | 1 | Reader-motion indication (tape variant) |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 2*BYTE_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | One-cycle load-complete pulse |
| done_addr | output | ADDR_W | Start address of the loaded program, valid with `done` |

## Verification
In the serial variant the store of the final word and the following byte strobe fall together: the next byte arrives while the machine is in `ST_FINISH`, and again in the cycle that `done` is high. The bench provokes this by holding `byte_vld` asserted across the end of the load. It judges the outcome by requiring exactly 62 writes, the last one at the expected address, and a single `done` pulse. In the tape variant a byte strobe is placed in the motion gap after a high byte; the stored word must still hold the pair that was properly handshaked.

// File: rtl/loader_pkg.sv
package loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_HI_WAIT,
        ST_HI_GAP,
        ST_LO_WAIT,
        ST_LO_GAP,
        ST_FINISH
    } ld_state_e;

endpackage

// File: rtl/loader_word_pack.sv
// Holds the high byte of the word under assembly; cleared after each store.
module loader_word_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take_hi,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] hi_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (clr) begin
            hi_q <= '0;
        end else if (take_hi) begin
            hi_q <= byte_in;
        end
    end

endmodule

// File: rtl/loader_progress.sv
// Store pointer (pre-incremented) and negative-preset word counter.
module loader_progress #(
    parameter int                ADDR_W     = 16,
    parameter int                WORD_COUNT = 62,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'o3677
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr_next,
    output logic              on_last,
    output logic              expired
);

    localparam int CNT_W = $clog2(WORD_COUNT + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_PRESET = CNT_W'(0) - CNT_W'(WORD_COUNT);

    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (init) begin
            ptr_q <= BASE_ADDR;
            cnt_q <= CNT_PRESET;
        end else if (step) begin
            ptr_q <= ptr_next;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ptr_next = ptr_q + 1'b1;
    assign on_last  = (cnt_q == {CNT_W{1'b1}});
    assign expired  = (cnt_q == '0);

endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader #(
    parameter int              BYTE_W      = 8,
    parameter int              ADDR_W      = 16,
    parameter int              WORD_COUNT  = 62,
    parameter bit              TAPE_MODE   = 1'b1,
    parameter logic [ADDR_W-1:0] TAPE_BASE   = 16'o3677,
    parameter logic [ADDR_W-1:0] SERIAL_BASE = 16'o37677,
    parameter logic [BYTE_W-1:0] SYNC_BYTE   = 8'h02
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  byte_vld,
    input  logic [BYTE_W-1:0]     byte_val,
    input  logic                  rdr_moving,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [2*BYTE_W-1:0]   mem_wdata,
    output logic                  mem_we,
    output logic                  done,
    output logic [ADDR_W-1:0]     done_addr
);
    import loader_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_ADDR  = TAPE_MODE ? TAPE_BASE : SERIAL_BASE;
    localparam logic [ADDR_W-1:0] START_ADDR = BASE_ADDR + 1'b1;

    ld_state_e         state, next_state;
    logic              take_hi, store, init;
    logic [BYTE_W-1:0] hi_q;
    logic [ADDR_W-1:0] ptr_next;
    logic              on_last, expired;

    loader_word_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (store),
        .take_hi (take_hi),
        .byte_in (byte_val),
        .hi_q    (hi_q)
    );

    loader_progress #(
        .ADDR_W     (ADDR_W),
        .WORD_COUNT (WORD_COUNT),
        .BASE_ADDR  (BASE_ADDR)
    ) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .step     (store),
        .ptr_next (ptr_next),
        .on_last  (on_last),
        .expired  (expired)
    );

    // Next-state and control decode
    always_comb begin
        next_state = state;
        take_hi    = 1'b0;
        store      = 1'b0;
        init       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    init       = 1'b1;
                    next_state = ST_HUNT;
                end
            end
            ST_HUNT: begin
                if (byte_vld && byte_val == SYNC_BYTE) next_state = ST_HI_WAIT;
            end
            ST_HI_WAIT: begin
                if (byte_vld) begin
                    take_hi    = 1'b1;
                    next_state = TAPE_MODE ? ST_HI_GAP : ST_LO_WAIT;
                end
            end
            ST_HI_GAP: begin
                if (rdr_moving) next_state = ST_LO_WAIT;
            end
            ST_LO_WAIT: begin
                if (byte_vld) begin
                    store = 1'b1;
                    if (TAPE_MODE)    next_state = ST_LO_GAP;
                    else if (on_last) next_state = ST_FINISH;
                    else              next_state = ST_HI_WAIT;
                end
            end
            ST_LO_GAP: begin
                if (rdr_moving) next_state = expired ? ST_FINISH : ST_HI_WAIT;
            end
            ST_FINISH: next_state = ST_IDLE;
            default:   next_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            done_addr <= '0;
        end else begin
            mem_we <= store;
            if (store) begin
                mem_addr  <= ptr_next;
                mem_wdata <= {hi_q, byte_val};
            end
            done <= (state == ST_FINISH);
            if (state == ST_FINISH) done_addr <= START_ADDR;
        end
    end

endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
    parameter int                ADDR_W     = 16,
    parameter int                WORD_COUNT = 62,
    parameter logic [ADDR_W-1:0] START_ADDR = 16'o3700
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic [ADDR_W-1:0] done_addr
);

    int                wr_cnt;
    logic [ADDR_W-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt    <= 0;
            last_addr <= '0;
        end else if (done) begin
            wr_cnt <= 0;
        end else if (mem_we) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= mem_addr;
        end
    end

    p_we_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_first_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wr_cnt == 0) |-> mem_addr == START_ADDR);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wr_cnt != 0) |-> mem_addr == ADDR_W'(last_addr + 1'b1));

    p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wr_cnt == WORD_COUNT);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_addr == START_ADDR);

    p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

endmodule

bind boot_stream_loader loader_checker #(
    .ADDR_W     (ADDR_W),
    .WORD_COUNT (WORD_COUNT),
    .START_ADDR (START_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .done      (done),
    .done_addr (done_addr)
);

// File: tb/boot_stream_loader_tb.sv
`timescale 1ns/1ps
module boot_stream_loader_tb_top;

    localparam int NW = 62;
    localparam logic [15:0] START_T = 16'o3700;
    localparam logic [15:0] START_S = 16'o37700;
    localparam logic [15:0] VEC [8] = '{16'h0201, 16'hFF00, 16'h00FF, 16'hA55A,
                                        16'h0102, 16'h8001, 16'h7FFE, 16'h1234};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start_t = 0, vld_t = 0, mov_t = 0;
    logic [7:0]  byte_t = 0;
    logic [15:0] addr_t, data_t, daddr_t;
    logic        we_t, done_t;

    logic        start_s = 0, vld_s = 0;
    logic [7:0]  byte_s = 0;
    logic [15:0] addr_s, data_s, daddr_s;
    logic        we_s, done_s;

    boot_stream_loader #(.TAPE_MODE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_t), .byte_vld(vld_t), .byte_val(byte_t),
        .rdr_moving(mov_t), .mem_addr(addr_t), .mem_wdata(data_t), .mem_we(we_t),
        .done(done_t), .done_addr(daddr_t));

    boot_stream_loader #(.TAPE_MODE(1'b0)) dut_s (
        .clk(clk), .rst_n(rst_n), .start(start_s), .byte_vld(vld_s), .byte_val(byte_s),
        .rdr_moving(1'b0), .mem_addr(addr_s), .mem_wdata(data_s), .mem_we(we_s),
        .done(done_s), .done_addr(daddr_s));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Write / done monitors, sampled on the falling edge
    logic [15:0] la_t [128], ld_t [128], la_s [128], ld_s [128];
    int n_wr_t = 0, n_wr_s = 0, n_done_t = 0, n_done_s = 0;
    logic [15:0] seen_da_t = 0, seen_da_s = 0;
    bit pw_t = 0, pd_t = 0, pw_s = 0, pd_s = 0;
    int long_t = 0, long_s = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (we_t) begin
                if (n_wr_t < 128) begin la_t[n_wr_t] = addr_t; ld_t[n_wr_t] = data_t; end
                n_wr_t++;
            end
            if (done_t) begin n_done_t++; seen_da_t = daddr_t; end
            if ((we_t && pw_t) || (done_t && pd_t)) long_t++;
            if (we_s) begin
                if (n_wr_s < 128) begin la_s[n_wr_s] = addr_s; ld_s[n_wr_s] = data_s; end
                n_wr_s++;
            end
            if (done_s) begin n_done_s++; seen_da_s = daddr_s; end
            if ((we_s && pw_s) || (done_s && pd_s)) long_s++;
            pw_t = we_t; pd_t = done_t; pw_s = we_s; pd_s = done_s;
        end
    end

    function automatic logic [15:0] word_of(int i);
        if (i < 8) return VEC[i];
        return 16'((i * 37) ^ ((i * 11) << 8));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic t_byte(input logic [7:0] b);
        @(negedge clk); vld_t = 1; byte_t = b;
        @(negedge clk); vld_t = 0;
    endtask

    task automatic t_move();
        @(negedge clk); mov_t = 1;
        @(negedge clk); mov_t = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(we_t == 0 && done_t == 0, "R1 reset tape", {we_t, done_t}, 0);
        chk(we_s == 0 && done_s == 0, "R1 reset serial", {we_s, done_s}, 0);
        rst_n = 1;
        // R1: bytes before start do nothing
        t_byte(8'h02); t_byte(8'h05); t_move(); t_byte(8'h07); t_move();
        idle(3);
        chk(n_wr_t == 0, "R1 no write before start", n_wr_t, 0);

        // ---- tape variant ----
        @(negedge clk); start_t = 1; @(negedge clk); start_t = 0;
        // R2: garbage before sync
        t_byte(8'h00); t_byte(8'h03); t_byte(8'hFF); t_byte(8'h82);
        idle(3);
        chk(n_wr_t == 0, "R2 pre-sync discarded", n_wr_t, 0);
        t_byte(8'h02);
        for (int i = 0; i < NW; i++) begin
            logic [15:0] w;
            w = word_of(i);
            t_byte(w[15:8]);
            if (i == 3) t_byte(8'hEE);   // R7: stray strobe in the motion gap
            t_move();
            t_byte(w[7:0]);
            if (i == NW - 1) begin
                idle(3);
                chk(n_done_t == 0, "R7 no done before final motion", n_done_t, 0);
            end
            t_move();
        end
        idle(4);
        chk(n_wr_t == NW, "R5 tape word count", n_wr_t, NW);
        for (int i = 0; i < NW && i < n_wr_t; i++) begin
            chk(la_t[i] == START_T + 16'(i), "R4 tape address", la_t[i], START_T + 16'(i));
            chk(ld_t[i] == word_of(i), "R3 tape data", ld_t[i], word_of(i));
        end
        chk(ld_t[3] == VEC[3], "R7 gap strobe ignored", ld_t[3], VEC[3]);
        chk(n_done_t == 1, "R6 tape one done", n_done_t, 1);
        chk(seen_da_t == START_T, "R6 tape done_addr", seen_da_t, START_T);
        chk(long_t == 0, "R10 tape single-cycle pulses", long_t, 0);

        // R9: after done, bytes ignored until start
        t_byte(8'h02); t_byte(8'h11); t_move(); t_byte(8'h22); t_move();
        idle(3);
        chk(n_wr_t == NW, "R9 ignored after done", n_wr_t, NW);
        @(negedge clk); start_t = 1; @(negedge clk); start_t = 0;
        t_byte(8'h02); t_byte(8'hBE); t_move(); t_byte(8'hEF); t_move();
        idle(3);
        chk(n_wr_t == NW + 1, "R9 restart writes", n_wr_t, NW + 1);
        chk(la_t[NW] == START_T, "R9 restart address", la_t[NW], START_T);
        chk(ld_t[NW] == 16'hBEEF, "R9 restart data", ld_t[NW], 16'hBEEF);

        // ---- serial variant: continuous strobe across the end of load ----
        @(negedge clk); start_s = 1; @(negedge clk); start_s = 0;
        for (int k = 0; k < 3 + 1 + 2 * NW + 4; k++) begin
            logic [7:0] b;
            if (k < 3)             b = 8'(k == 1 ? 8'h03 : 8'h00);
            else if (k == 3)       b = 8'h02;
            else if (k < 4 + 2 * NW) begin
                logic [15:0] w;
                w = word_of((k - 4) / 2);
                b = ((k - 4) % 2 == 0) ? w[15:8] : w[7:0];
            end
            else                   b = 8'h55;
            @(negedge clk); vld_s = 1; byte_s = b;
        end
        @(negedge clk); vld_s = 0;
        idle(4);
        chk(n_wr_s == NW, "R8 serial back-to-back count", n_wr_s, NW);
        for (int i = 0; i < NW && i < n_wr_s; i++) begin
            chk(la_s[i] == START_S + 16'(i), "R4 serial address", la_s[i], START_S + 16'(i));
            chk(ld_s[i] == word_of(i), "R3 serial data", ld_s[i], word_of(i));
        end
        chk(n_done_s == 1, "R6 serial one done", n_done_s, 1);
        chk(seen_da_s == START_S, "R6 serial done_addr", seen_da_s, START_S);
        chk(long_s == 0, "R10 serial single-cycle pulses", long_s, 0);
        finish_up();
    end

endmodule